// File: doc/BRIEF.md
# Multi-Source Clock Frequency Meter

This block measures the frequency of one clock picked from a bank of up to 128 on-chip clocks. Software writes a source index and a gate length in microseconds, sets the enable and start bits, polls a busy flag, and then reads a 16-bit count of source rising edges seen during the gate. The frequency in Hz is the count times one million divided by the gate length. That conversion is done by software.

The gate is timed in the reference clock domain. A prescaler turns the reference clock into a one-microsecond tick. The gate level is carried into the domain of the measured clock through a synchroniser, and the edges are counted there. The count is returned to the reference domain through a four-phase request/acknowledge handshake before busy drops. The counter stops at all-ones. Software that reads 0xFFFF knows the gate was too long for that clock and can retry with a shorter one. A continuous mode restarts the gate after every result. An optional one-cycle interrupt marks each completion.

Top module: `freq_meter`

## Requirements
- R1: After reset, the control word at byte offset 0x4 reads 0, the result at offset 0xC reads 0, and irq is low.
- R2: The control word at 0x4 has these fields:
  - bits 15:0: gate length minus one.
  - bit 16: enable.
  - bit 17: continuous mode.
  - bit 18: interrupt enable.
  - bit 19: start. It is never stored and always reads 0.
  - bits 26:20: source index.
  - bit 31: busy. It is read-only.

  The other fields read back as last written. A start written with enable 0 begins nothing.
- R3: Offsets 0x0 and 0x8 always read 0. Writes to 0x0, 0x8 and 0xC change no readable state.
- R4: A measurement started with gate field L counts the rising edges of `src_clk[index]` over (L+1) microseconds, to within ±2 edges. One microsecond is TICK_DIV reference cycles. The count is then placed in bits 15:0 of offset 0xC.
- R5: Busy rises on the clock edge that accepts a start. It stays high for at least (L+1)·TICK_DIV cycles, until the result is final, and then falls.
- R6: The result saturates at 0xFFFF when more edges occur than 16 bits can hold.
- R7: A start written while busy is high is ignored. The running measurement keeps its own source and gate.
- R8: Writing the control word with enable 0 during a measurement clears busy on that edge. No result is stored and no interrupt is raised for that measurement.
- R9: In continuous mode, a new gate begins as soon as each result is taken. Busy stays high and the result keeps updating.
- R10: With interrupt enable set, irq is high for exactly one reference cycle per completed measurement. With it clear, irq stays low.
- R11: The source index and gate length are captured at start. Changing those fields during a measurement only alters the readback value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, bus clock |
| ref_arst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_clk | input | NUM_SRC | Candidate clocks to be measured |
| irq | output | 1 | Completion pulse, one reference cycle |

## Verification
The assertions take for granted that the bus inputs change only in step with the reference clock. They also assume the selected source clock keeps running for the whole measurement, because both the gate echo and the result handshake need its edges to advance. The bench drives every bus access half a cycle away from the sampling edge. It only ever selects the four indices that carry a running clock: 100, 40, 125 and 500 MHz. The random draws of source and gate length are restricted to those indices and to gates short enough to finish within the run.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_DUTY = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_AUX  = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_RES  = 4'hC;

  localparam int unsigned BIT_EN   = 16;
  localparam int unsigned BIT_CONT = 17;
  localparam int unsigned BIT_IRQ  = 18;
  localparam int unsigned BIT_RUN  = 19;
  localparam int unsigned SRC_LO   = 20;
  localparam int unsigned BIT_BUSY = 31;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_GATE     = 2'd1,
    ST_WAIT_REQ = 2'd2,
    ST_WAIT_REL = 2'd3
  } fm_state_e;
endpackage

// File: rtl/fm_rst_sync.sv
module fm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= 2'b00;
    else         sr_q <= {sr_q[0], 1'b1};
  end

  assign srst_n = sr_q[1];
endmodule

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_d;

  assign st_d = {st_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/fm_tick_gen.sv
module fm_tick_gen #(
  parameter int unsigned TICK_DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_direct
      logic unused_tick_in;
      assign unused_tick_in = clk ^ rst_n ^ clr;
      assign tick = 1'b1;
    end else begin : g_count
      localparam int unsigned CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      always_comb begin
        if (clr)                cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + CW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/fm_edge_counter.sv
module fm_edge_counter #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             meas_clk,
  input  logic             arst_n,
  input  logic             gate_async,
  input  logic             ack_async,
  output logic [CNT_W-1:0] count,
  output logic             req,
  output logic             gate_seen
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             rst_n;
  logic             gate_s;
  logic             ack_s;
  logic             gate_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;

  fm_rst_sync u_rst (.clk(meas_clk), .arst_n(arst_n), .srst_n(rst_n));

  fm_sync #(.STAGES(SYNC_DEPTH)) u_gate_sync (
    .clk(meas_clk), .rst_n(rst_n), .d(gate_async), .q(gate_s));

  fm_sync #(.STAGES(SYNC_DEPTH)) u_ack_sync (
    .clk(meas_clk), .rst_n(rst_n), .d(ack_async), .q(ack_s));

  // count while the gate is seen open, hold afterwards, raise the request
  // once the gate is seen closed, release on acknowledge
  always_comb begin
    cnt_d = cnt_q;
    req_d = req_q;
    if (ack_s) begin
      cnt_d = '0;
      req_d = 1'b0;
    end else if (gate_s) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
    end else if (gate_q) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge meas_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      req_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      req_q  <= req_d;
      gate_q <= gate_s;
    end
  end

  assign count     = cnt_q;
  assign req       = req_q;
  assign gate_seen = gate_s;
endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned SRC_W = 7,
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              tick,
  input  logic              echo_s,
  input  logic              req_s,
  input  logic [CNT_W-1:0]  meas_count,
  output logic              gate,
  output logic              tick_clr,
  output logic [SRC_W-1:0]  act_src,
  output logic              busy,
  output logic              irq,
  output logic              en,
  output logic [CNT_W-1:0]  result
);
  // programmed fields
  logic [LEN_W-1:0] len_q, len_d;
  logic             en_q, en_d;
  logic             cont_q, cont_d;
  logic             irqen_q, irqen_d;
  logic [SRC_W-1:0] src_q, src_d;
  // working state
  fm_state_e        st_q, st_d;
  logic [LEN_W-1:0] alen_q, alen_d;
  logic [SRC_W-1:0] asrc_q, asrc_d;
  logic [LEN_W-1:0] tcnt_q, tcnt_d;
  logic             tup_q, tup_d;
  logic             disc_q, disc_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic             irq_q, irq_d;
  logic             gate_q, gate_d;

  logic ctrl_wr, start, abort;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;
  assign ctrl_wr = bus_we && (bus_addr == OFS_CTRL);
  assign start   = ctrl_wr && bus_wdata[BIT_RUN] && bus_wdata[BIT_EN] && (st_q == ST_IDLE);
  assign abort   = ctrl_wr && !bus_wdata[BIT_EN] && (st_q != ST_IDLE);

  always_comb begin
    len_d    = len_q;
    en_d     = en_q;
    cont_d   = cont_q;
    irqen_d  = irqen_q;
    src_d    = src_q;
    st_d     = st_q;
    alen_d   = alen_q;
    asrc_d   = asrc_q;
    tcnt_d   = tcnt_q;
    tup_d    = tup_q;
    disc_d   = disc_q;
    res_d    = res_q;
    irq_d    = 1'b0;
    tick_clr = 1'b0;

    if (ctrl_wr) begin
      len_d   = bus_wdata[LEN_W-1:0];
      en_d    = bus_wdata[BIT_EN];
      cont_d  = bus_wdata[BIT_CONT];
      irqen_d = bus_wdata[BIT_IRQ];
      src_d   = bus_wdata[SRC_LO +: SRC_W];
    end
    if (abort) disc_d = 1'b1;

    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d     = ST_GATE;
          alen_d   = bus_wdata[LEN_W-1:0];
          asrc_d   = bus_wdata[SRC_LO +: SRC_W];
          tcnt_d   = '0;
          tup_d    = 1'b0;
          tick_clr = 1'b1;
        end
      end
      ST_GATE: begin
        if (tick) tcnt_d = tcnt_q + LEN_W'(1);
        if ((tick && (tcnt_q == alen_q)) || abort) tup_d = 1'b1;
        // the gate only closes once the far side has seen it open
        if (tup_d && echo_s) st_d = ST_WAIT_REQ;
      end
      ST_WAIT_REQ: begin
        if (req_s) begin
          if (!disc_d) res_d = meas_count;
          st_d = ST_WAIT_REL;
        end
      end
      ST_WAIT_REL: begin
        if (!req_s) begin
          if (disc_d) begin
            st_d   = ST_IDLE;
            disc_d = 1'b0;
          end else begin
            irq_d = irqen_q;
            if (cont_q && en_q) begin
              st_d     = ST_GATE;
              tcnt_d   = '0;
              tup_d    = 1'b0;
              tick_clr = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase

    gate_d = (st_d == ST_GATE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      en_q    <= 1'b0;
      cont_q  <= 1'b0;
      irqen_q <= 1'b0;
      src_q   <= '0;
      st_q    <= ST_IDLE;
      alen_q  <= '0;
      asrc_q  <= '0;
      tcnt_q  <= '0;
      tup_q   <= 1'b0;
      disc_q  <= 1'b0;
      res_q   <= '0;
      irq_q   <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      len_q   <= len_d;
      en_q    <= en_d;
      cont_q  <= cont_d;
      irqen_q <= irqen_d;
      src_q   <= src_d;
      st_q    <= st_d;
      alen_q  <= alen_d;
      asrc_q  <= asrc_d;
      tcnt_q  <= tcnt_d;
      tup_q   <= tup_d;
      disc_q  <= disc_d;
      res_q   <= res_d;
      irq_q   <= irq_d;
      gate_q  <= gate_d;
    end
  end

  assign busy = (st_q != ST_IDLE) && !disc_q;

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[LEN_W-1:0]         = len_q;
        bus_rdata[BIT_EN]            = en_q;
        bus_rdata[BIT_CONT]          = cont_q;
        bus_rdata[BIT_IRQ]           = irqen_q;
        bus_rdata[SRC_LO +: SRC_W]   = src_q;
        bus_rdata[BIT_BUSY]          = busy;
      end
      OFS_RES:  bus_rdata[CNT_W-1:0] = res_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign gate    = gate_q;
  assign act_src = asrc_q;
  assign irq     = irq_q;
  assign en      = en_q;
  assign result  = res_q;
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int unsigned NUM_SRC    = 128,
  parameter int unsigned TICK_DIV   = 250,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic               ref_clk,
  input  logic               ref_arst_n,
  input  logic               bus_we,
  input  logic [3:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_clk,
  output logic               irq
);
  localparam int unsigned SRC_W = $clog2(NUM_SRC);

  logic             rst_s_n;
  logic             tick, tick_clr;
  logic             gate_w, echo_s, req_s;
  logic             gate_seen, meas_req;
  logic [CNT_W-1:0] meas_count;
  logic [SRC_W-1:0] act_src;
  logic             meas_clk;
  logic             busy_w, en_w;
  logic [CNT_W-1:0] res_w;

  fm_rst_sync u_ref_rst (.clk(ref_clk), .arst_n(ref_arst_n), .srst_n(rst_s_n));

  fm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(ref_clk), .rst_n(rst_s_n), .clr(tick_clr), .tick(tick));

  fm_ctrl #(.LEN_W(LEN_W), .SRC_W(SRC_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(ref_clk), .rst_n(rst_s_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .echo_s(echo_s), .req_s(req_s), .meas_count(meas_count),
    .gate(gate_w), .tick_clr(tick_clr), .act_src(act_src),
    .busy(busy_w), .irq(irq), .en(en_w), .result(res_w));

  assign meas_clk = src_clk[act_src];

  fm_edge_counter #(.CNT_W(CNT_W), .SYNC_DEPTH(SYNC_DEPTH)) u_cnt (
    .meas_clk(meas_clk), .arst_n(ref_arst_n),
    .gate_async(gate_w), .ack_async(req_s),
    .count(meas_count), .req(meas_req), .gate_seen(gate_seen));

  fm_sync #(.STAGES(SYNC_DEPTH)) u_echo_sync (
    .clk(ref_clk), .rst_n(rst_s_n), .d(gate_seen), .q(echo_s));

  fm_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
    .clk(ref_clk), .rst_n(rst_s_n), .d(meas_req), .q(req_s));
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic             wr_en_bit,
  input logic             wr_run_bit,
  input logic             busy,
  input logic             irq,
  input logic             en,
  input logic [CNT_W-1:0] result
);
  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_we && bus_addr == 4'h4 && wr_run_bit && wr_en_bit));

  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'h4 && !wr_en_bit) |=> !busy);

  // R8
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !busy);

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $past(busy));
endmodule

bind freq_meter fm_checker #(.CNT_W(CNT_W)) u_fm_chk (
  .clk(ref_clk), .rst_n(rst_s_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wr_en_bit(bus_wdata[16]), .wr_run_bit(bus_wdata[19]),
  .busy(busy_w), .irq(irq), .en(en_w), .result(res_w));

// File: tb/test_freq_meter.sv
`timescale 1ns/1ps
module test_freq_meter;
  localparam int TICK = 250;

  logic        ref_clk = 1'b0;
  logic        ref_arst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        s0 = 1'b0, s5 = 1'b0, s77 = 1'b0, s127 = 1'b0;
  logic [127:0] src_clk;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit finished = 1'b0;

  assign src_clk = {s127, 49'b0, s77, 71'b0, s5, 4'b0, s0};

  always #2    ref_clk = ~ref_clk;
  always #5    s0   = ~s0;
  always #12.5 s5   = ~s5;
  always #4    s77  = ~s77;
  always #1    s127 = ~s127;

  freq_meter #(.TICK_DIV(TICK)) i_freq_meter (
    .ref_clk(ref_clk), .ref_arst_n(ref_arst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_clk(src_clk), .irq(irq));

  always @(negedge ref_clk) if (irq === 1'b1) irq_cnt++;

  function automatic int src_mhz(input int idx);
    case (idx)
      0: return 100;
      5: return 40;
      77: return 125;
      127: return 500;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_count(input int idx, input int n_us);
    int e;
    e = src_mhz(idx) * n_us;
    return (e > 65535) ? 65535 : e;
  endfunction

  function automatic logic [31:0] mk_ctrl(input int idx, input int n_us, input bit en,
                                          input bit cont, input bit ie, input bit run);
    logic [31:0] w;
    w = '0;
    w[15:0]  = 16'(n_us - 1);
    w[16]    = en;
    w[17]    = cont;
    w[18]    = ie;
    w[19]    = run;
    w[26:20] = 7'(idx);
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge ref_clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge ref_clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge ref_clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(output int cycles);
    logic [31:0] v;
    cycles = 0;
    do begin
      bus_read(4'h4, v);
      cycles++;
    end while (v[31] && cycles < 100000);
  endtask

  task automatic measure(input int idx, input int n_us, input bit ie, input string tag,
                         output int res);
    logic [31:0] v;
    int cyc, e;
    bus_write(4'h4, mk_ctrl(idx, n_us, 1'b1, 1'b0, ie, 1'b1));
    bus_read(4'h4, v);
    check(v[31] == 1'b1, {tag, " R5 busy after start"}, v[31], 1);
    wait_idle(cyc);
    check(cyc >= n_us * TICK - 1 && cyc <= n_us * TICK + 80, {tag, " R5 busy length"},
          cyc, n_us * TICK);
    bus_read(4'hC, v);
    res = int'(v[15:0]);
    e = exp_count(idx, n_us);
    if (e == 65535)
      check(res == 65535, {tag, " R6 saturated count"}, res, e);
    else
      check(res >= e - 2 && res <= e + 2, {tag, " R4 edge count"}, res, e);
  endtask

  initial begin
    logic [31:0] v;
    int r, base, cyc, prev;
    void'($urandom(32'd4242));
    repeat (5) @(negedge ref_clk);
    ref_arst_n = 1'b1;
    repeat (5) @(negedge ref_clk);

    // R1 reset state
    bus_read(4'h4, v); check(v == 32'h0, "R1 control after reset", v, 0);
    bus_read(4'hC, v); check(v == 32'h0, "R1 result after reset", v, 0);
    check(irq == 1'b0, "R1 irq after reset", irq, 0);

    // R3 reserved offsets
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_read(4'h0, v); check(v == 32'h0, "R3 offset 0x0 reads zero", v, 0);
    bus_read(4'h8, v); check(v == 32'h0, "R3 offset 0x8 reads zero", v, 0);
    bus_read(4'hC, v); check(v == 32'h0, "R3 result untouched by write", v, 0);
    bus_read(4'h4, v); check(v == 32'h0, "R3 control untouched", v, 0);

    // R2 field readback, start bit not stored, start without enable ignored
    bus_write(4'h4, 32'h00D7_1234);
    bus_read(4'h4, v); check(v == 32'h00D7_1234, "R2 readback", v, 32'h00D7_1234);
    bus_write(4'h4, 32'h00D8_1234);
    bus_read(4'h4, v); check(v == 32'h00D0_1234, "R2 run without enable", v, 32'h00D0_1234);
    bus_write(4'h4, 32'h0);

    // R4 / R10 directed, interrupt off then on
    base = irq_cnt;
    measure(0, 3, 1'b0, "dir0", r);
    check(irq_cnt == base, "R10 no irq when disabled", irq_cnt, base);
    base = irq_cnt;
    measure(5, 2, 1'b1, "dir1", r);
    check(irq_cnt == base + 1, "R10 one irq pulse", irq_cnt, base + 1);

    // R6 saturation
    measure(127, 200, 1'b0, "sat", r);

    // R7 / R11 start and field change while busy
    bus_write(4'h4, mk_ctrl(0, 4, 1'b1, 1'b0, 1'b0, 1'b1));
    repeat (10) @(negedge ref_clk);
    bus_write(4'h4, mk_ctrl(5, 1, 1'b1, 1'b0, 1'b0, 1'b1));
    bus_write(4'h4, mk_ctrl(77, 1, 1'b1, 1'b0, 1'b0, 1'b0));
    wait_idle(cyc);
    check(cyc >= 4 * TICK - 40, "R7 running gate kept", cyc, 4 * TICK);
    bus_read(4'hC, v);
    check(v[15:0] >= 398 && v[15:0] <= 402, "R7 R11 result from captured source", v[15:0], 400);
    bus_read(4'h4, v);
    check(v == mk_ctrl(77, 1, 1'b1, 1'b0, 1'b0, 1'b0), "R11 readback holds new fields",
          v, mk_ctrl(77, 1, 1'b1, 1'b0, 1'b0, 1'b0));

    // R8 abort
    bus_read(4'hC, v); prev = int'(v[15:0]);
    base = irq_cnt;
    bus_write(4'h4, mk_ctrl(0, 20, 1'b1, 1'b0, 1'b1, 1'b1));
    repeat (100) @(negedge ref_clk);
    bus_write(4'h4, 32'h0);
    bus_read(4'h4, v); check(v[31] == 1'b0, "R8 busy cleared by abort", v[31], 0);
    repeat (300) @(negedge ref_clk);
    bus_read(4'hC, v); check(int'(v[15:0]) == prev, "R8 result kept after abort", v[15:0], prev);
    check(irq_cnt == base, "R8 no irq after abort", irq_cnt, base);

    // R9 continuous mode
    base = irq_cnt;
    bus_write(4'h4, mk_ctrl(0, 2, 1'b1, 1'b1, 1'b1, 1'b1));
    cyc = 0;
    while (irq_cnt < base + 3 && cyc < 5000) begin @(negedge ref_clk); cyc++; end
    check(irq_cnt >= base + 3, "R9 repeated completions", irq_cnt, base + 3);
    bus_read(4'h4, v); check(v[31] == 1'b1, "R9 busy stays high", v[31], 1);
    bus_read(4'hC, v);
    check(v[15:0] >= 198 && v[15:0] <= 202, "R9 continuous result", v[15:0], 200);
    bus_write(4'h4, 32'h0);
    repeat (600) @(negedge ref_clk);
    bus_read(4'h4, v); check(v[31] == 1'b0, "R8 continuous stopped", v[31], 0);

    // random mix
    for (int i = 0; i < 8; i++) begin
      int pick, idx, n;
      pick = int'($urandom_range(0, 3));
      idx = (pick == 0) ? 0 : (pick == 1) ? 5 : (pick == 2) ? 77 : 127;
      n = int'($urandom_range(1, 6));
      measure(idx, n, 1'b0, "rand R4", r);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge ref_clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule